// File: doc/BRIEF.md
# Double-Buffered Frame Swap Controller

This block sits between two frame memories and two agents: a drawing agent that composes pictures and a display agent that scans them out. At any moment one memory is wired to the drawing side and the other to the display side. Every address, write-data and control line of both memory ports passes through a 2-to-1 crossbar. The read data returned from the memories is steered back through the same crossbar.

The two sides trade buffers through a two-flag handshake. When a frame is complete, the drawing side pulses a strobe. This sets a picture-ready flag and stalls the drawer. The display side keeps repeating its current frame. At each end-of-frame pulse it looks at picture-ready, and if that flag is set it raises an acknowledge flag. With both flags set, a single bank-select register toggles in the same clock cycle in which both flags clear. From that edge on, the memories have exchanged roles.

Top module: `frame_swap_ctrl`

## Requirements
- R1: After reset, `bank_sel` is 0, meaning memory 0 serves the drawer and memory 1 the display. `pic_ready`, `disp_ack` and `draw_stall` are all low.
- R2: A `frame_done` pulse seen while `pic_ready` is low sets `pic_ready` on the next clock edge.
- R3: A `disp_eof` pulse seen while `pic_ready` is low leaves `disp_ack` low and `bank_sel` unchanged, so the display keeps reading the same memory.
- R4: A `disp_eof` pulse seen while `pic_ready` is high and `disp_ack` is low sets `disp_ack` on the next edge.
- R5: In a cycle where both `pic_ready` and `disp_ack` are high, the next edge toggles `bank_sel` and clears both flags together. `bank_sel` never changes at any other time.
- R6: `draw_stall` is high from the edge that sets `pic_ready` until the edge that performs the swap, and low otherwise.
- R7: A `frame_done` pulse seen while `pic_ready` is already high has no effect: no flag changes and no further swap follows.
- R8: With `bank_sel` = 0, memory 0 carries the drawing port's address, write data, read, write and select, and memory 1 carries the display port's address, read and select. With `bank_sel` = 1 the roles are mirrored. The memory on the display side always sees write = 0 and write data = 0.
- R9: Read data is returned to the port that issued the read, from the memory that was routed to that port in the issuing cycle. This holds even when a swap falls between the read request and the returned data. The read latency is `RD_LAT` cycles (default 1).
- R10: If `disp_eof` is pulsed in cycle k while `pic_ready` is high and `disp_ack` is low, a display access in cycle k+1 still reaches the old memory, and one in cycle k+2 or later reaches the new memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_done | input | 1 | One-cycle strobe: drawing side finished a frame |
| draw_stall | output | 1 | Drawing side must not start a new frame |
| draw_addr | input | AW | Drawing-side address |
| draw_wdata | input | DW | Drawing-side write data |
| draw_rd | input | 1 | Drawing-side read request |
| draw_wr | input | 1 | Drawing-side write request |
| draw_sel | input | 1 | Drawing-side select |
| draw_rdata | output | DW | Read data returned to the drawing side |
| disp_eof | input | 1 | One-cycle strobe: display finished a full frame |
| disp_addr | input | AW | Display-side address |
| disp_rd | input | 1 | Display-side read request |
| disp_sel | input | 1 | Display-side select |
| disp_rdata | output | DW | Read data returned to the display side |
| m0_addr | output | AW | Memory 0 address |
| m0_wdata | output | DW | Memory 0 write data |
| m0_rd | output | 1 | Memory 0 read |
| m0_wr | output | 1 | Memory 0 write |
| m0_sel | output | 1 | Memory 0 select |
| m0_rdata | input | DW | Memory 0 read data |
| m1_addr | output | AW | Memory 1 address |
| m1_wdata | output | DW | Memory 1 write data |
| m1_rd | output | 1 | Memory 1 read |
| m1_wr | output | 1 | Memory 1 write |
| m1_sel | output | 1 | Memory 1 select |
| m1_rdata | input | DW | Memory 1 read data |
| bank_sel | output | 1 | 0: memory 0 draws; 1: memory 1 draws |
| pic_ready | output | 1 | Picture-ready flag |
| disp_ack | output | 1 | Display acknowledge flag |

## Verification
The handshake is driven through a fixed sequence of strobe combinations: end-of-frame with no picture pending, a completed frame followed by repeated frames, duplicate completion strobes, and both strobes in the same cycle. These patterns separate a correct two-flag swap from one that swaps on a single flag, double-swaps, or samples the flag too early. Routing is tested in both bank states with distinct preloaded contents in each memory, so a wrong crossbar leg returns a recognisably wrong value. A read issued in the very cycle of a swap shows whether returned data follows the issuing cycle's routing or the current one. Accesses one and two cycles after an acknowledging end-of-frame pin down exactly when the swap takes effect for the display.

// File: rtl/fswap_pkg.sv
package fswap_pkg;

   // Which memory is wired to the drawing agent.
   typedef enum logic {
      MAP_M0_DRAWS = 1'b0,
      MAP_M1_DRAWS = 1'b1
   } bank_map_e;

   // Handshake flag pair.
   typedef struct packed {
      logic pic;   // picture ready, raised by drawing side
      logic ack;   // acknowledge, raised by display at a frame boundary
   } hs_flags_t;

   function automatic bank_map_e flip_map(bank_map_e m);
      return (m == MAP_M0_DRAWS) ? MAP_M1_DRAWS : MAP_M0_DRAWS;
   endfunction

endpackage

// File: rtl/fswap_handshake.sv
module fswap_handshake
   import fswap_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      frame_done,
   input  logic      disp_eof,
   output hs_flags_t flags,
   output bank_map_e map,
   output logic      swap_now
);

   hs_flags_t flags_q;
   bank_map_e map_q;

   // Both flags up: this edge exchanges the memories.
   assign swap_now = flags_q.pic & flags_q.ack;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flags_q <= '0;
         map_q   <= MAP_M0_DRAWS;
      end else if (swap_now) begin
         flags_q <= '0;
         map_q   <= flip_map(map_q);
      end else begin
         if (frame_done && !flags_q.pic)
            flags_q.pic <= 1'b1;
         if (disp_eof && flags_q.pic)
            flags_q.ack <= 1'b1;
      end
   end

   assign flags = flags_q;
   assign map   = map_q;

endmodule

// File: rtl/fswap_xbar.sv
module fswap_xbar #(
   parameter int AW = 16,
   parameter int DW = 16
) (
   input  logic          draw_bank,   // index of memory wired to the drawer
   input  logic [AW-1:0] draw_addr,
   input  logic [DW-1:0] draw_wdata,
   input  logic          draw_rd,
   input  logic          draw_wr,
   input  logic          draw_sel,
   input  logic [AW-1:0] disp_addr,
   input  logic          disp_rd,
   input  logic          disp_sel,
   output logic [AW-1:0] mem_addr  [2],
   output logic [DW-1:0] mem_wdata [2],
   output logic          mem_rd    [2],
   output logic          mem_wr    [2],
   output logic          mem_sel   [2]
);

   localparam logic [DW-1:0] NO_DATA = '0;

   for (genvar p = 0; p < 2; p++) begin : g_port
      logic takes_draw;
      assign takes_draw   = (draw_bank == 1'(p));
      assign mem_addr[p]  = takes_draw ? draw_addr  : disp_addr;
      assign mem_wdata[p] = takes_draw ? draw_wdata : NO_DATA;
      assign mem_rd[p]    = takes_draw ? draw_rd    : disp_rd;
      assign mem_wr[p]    = takes_draw ? draw_wr    : 1'b0;
      assign mem_sel[p]   = takes_draw ? draw_sel   : disp_sel;
   end

endmodule

// File: rtl/fswap_rdret.sv
module fswap_rdret #(
   parameter int DW     = 16,
   parameter int RD_LAT = 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          draw_bank,
   input  logic [DW-1:0] rdata0,
   input  logic [DW-1:0] rdata1,
   output logic [DW-1:0] draw_rdata,
   output logic [DW-1:0] disp_rdata
);

   logic ret_bank;   // routing that was in force when the data was requested

   if (RD_LAT == 0) begin : g_comb
      assign ret_bank = draw_bank;
   end else begin : g_pipe
      logic [RD_LAT-1:0] bank_pipe;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            bank_pipe <= '0;
         end else begin
            bank_pipe[0] <= draw_bank;
            for (int i = 1; i < RD_LAT; i++)
               bank_pipe[i] <= bank_pipe[i-1];
         end
      end
      assign ret_bank = bank_pipe[RD_LAT-1];
   end

   assign draw_rdata = ret_bank ? rdata1 : rdata0;
   assign disp_rdata = ret_bank ? rdata0 : rdata1;

endmodule

// File: rtl/frame_swap_ctrl.sv
module frame_swap_ctrl
   import fswap_pkg::*;
#(
   parameter int AW     = 16,
   parameter int DW     = 16,
   parameter int RD_LAT = 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          frame_done,
   output logic          draw_stall,
   input  logic [AW-1:0] draw_addr,
   input  logic [DW-1:0] draw_wdata,
   input  logic          draw_rd,
   input  logic          draw_wr,
   input  logic          draw_sel,
   output logic [DW-1:0] draw_rdata,
   input  logic          disp_eof,
   input  logic [AW-1:0] disp_addr,
   input  logic          disp_rd,
   input  logic          disp_sel,
   output logic [DW-1:0] disp_rdata,
   output logic [AW-1:0] m0_addr,
   output logic [DW-1:0] m0_wdata,
   output logic          m0_rd,
   output logic          m0_wr,
   output logic          m0_sel,
   input  logic [DW-1:0] m0_rdata,
   output logic [AW-1:0] m1_addr,
   output logic [DW-1:0] m1_wdata,
   output logic          m1_rd,
   output logic          m1_wr,
   output logic          m1_sel,
   input  logic [DW-1:0] m1_rdata,
   output logic          bank_sel,
   output logic          pic_ready,
   output logic          disp_ack
);

   if (AW < 1 || AW > 32) begin : g_bad_aw
      $error("frame_swap_ctrl: AW must be 1..32");
   end
   if (DW < 1 || DW > 256) begin : g_bad_dw
      $error("frame_swap_ctrl: DW must be 1..256");
   end
   if (RD_LAT < 0 || RD_LAT > 4) begin : g_bad_lat
      $error("frame_swap_ctrl: RD_LAT must be 0..4");
   end

   hs_flags_t flags;
   bank_map_e map;
   logic      swap_now;
   logic      draw_bank;

   fswap_handshake u_hs (
      .clk        (clk),
      .rst_n      (rst_n),
      .frame_done (frame_done),
      .disp_eof   (disp_eof),
      .flags      (flags),
      .map        (map),
      .swap_now   (swap_now)
   );

   assign draw_bank = (map == MAP_M1_DRAWS);

   logic [AW-1:0] x_addr  [2];
   logic [DW-1:0] x_wdata [2];
   logic          x_rd    [2];
   logic          x_wr    [2];
   logic          x_sel   [2];

   fswap_xbar #(.AW(AW), .DW(DW)) u_xbar (
      .draw_bank  (draw_bank),
      .draw_addr  (draw_addr),
      .draw_wdata (draw_wdata),
      .draw_rd    (draw_rd),
      .draw_wr    (draw_wr),
      .draw_sel   (draw_sel),
      .disp_addr  (disp_addr),
      .disp_rd    (disp_rd),
      .disp_sel   (disp_sel),
      .mem_addr   (x_addr),
      .mem_wdata  (x_wdata),
      .mem_rd     (x_rd),
      .mem_wr     (x_wr),
      .mem_sel    (x_sel)
   );

   assign m0_addr  = x_addr[0];
   assign m0_wdata = x_wdata[0];
   assign m0_rd    = x_rd[0];
   assign m0_wr    = x_wr[0];
   assign m0_sel   = x_sel[0];
   assign m1_addr  = x_addr[1];
   assign m1_wdata = x_wdata[1];
   assign m1_rd    = x_rd[1];
   assign m1_wr    = x_wr[1];
   assign m1_sel   = x_sel[1];

   fswap_rdret #(.DW(DW), .RD_LAT(RD_LAT)) u_ret (
      .clk        (clk),
      .rst_n      (rst_n),
      .draw_bank  (draw_bank),
      .rdata0     (m0_rdata),
      .rdata1     (m1_rdata),
      .draw_rdata (draw_rdata),
      .disp_rdata (disp_rdata)
   );

   assign bank_sel   = draw_bank;
   assign pic_ready  = flags.pic;
   assign disp_ack   = flags.ack;
   assign draw_stall = flags.pic;

endmodule

// File: rtl/fswap_checker.sv
module fswap_checker #(
   parameter int AW = 16,
   parameter int DW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          frame_done,
   input logic          disp_eof,
   input logic          draw_stall,
   input logic [AW-1:0] draw_addr,
   input logic [AW-1:0] disp_addr,
   input logic [AW-1:0] m0_addr,
   input logic [AW-1:0] m1_addr,
   input logic          m0_wr,
   input logic          m1_wr,
   input logic          bank_sel,
   input logic          pic_ready,
   input logic          disp_ack
);

   assert_pic_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_done && !pic_ready) |=> pic_ready);

   assert_no_early_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !pic_ready |=> !disp_ack);

   assert_ack_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (disp_eof && pic_ready && !disp_ack) |=> disp_ack);

   assert_swap_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (pic_ready && disp_ack) |=> (bank_sel != $past(bank_sel)) && !pic_ready && !disp_ack);

   assert_swap_only_on_both_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(bank_sel) |-> $past(pic_ready && disp_ack));

   assert_stall_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(draw_stall) |-> $past(disp_ack));

   assert_stall_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(draw_stall) |-> $past(frame_done));

   assert_route_R8: assert property (@(posedge clk) disable iff (!rst_n)
      bank_sel ? (m1_addr == draw_addr && m0_addr == disp_addr && !m0_wr)
               : (m0_addr == draw_addr && m1_addr == disp_addr && !m1_wr));

endmodule

bind frame_swap_ctrl fswap_checker #(.AW(AW), .DW(DW)) u_fswap_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .frame_done (frame_done),
   .disp_eof   (disp_eof),
   .draw_stall (draw_stall),
   .draw_addr  (draw_addr),
   .disp_addr  (disp_addr),
   .m0_addr    (m0_addr),
   .m1_addr    (m1_addr),
   .m0_wr      (m0_wr),
   .m1_wr      (m1_wr),
   .bank_sel   (bank_sel),
   .pic_ready  (pic_ready),
   .disp_ack   (disp_ack)
);

// File: tb/test_frame_swap_ctrl.sv
`timescale 1ns/1ps
module test_frame_swap_ctrl;

   localparam int AW = 4;
   localparam int DW = 8;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic          rst_n = 1'b0;
   logic          frame_done = 1'b0, disp_eof = 1'b0;
   logic          draw_stall;
   logic [AW-1:0] draw_addr = '0, disp_addr = '0;
   logic [DW-1:0] draw_wdata = '0;
   logic          draw_rd = 1'b0, draw_wr = 1'b0, draw_sel = 1'b0;
   logic          disp_rd = 1'b0, disp_sel = 1'b0;
   logic [DW-1:0] draw_rdata, disp_rdata;
   logic [AW-1:0] m0_addr, m1_addr;
   logic [DW-1:0] m0_wdata, m1_wdata;
   logic          m0_rd, m0_wr, m0_sel, m1_rd, m1_wr, m1_sel;
   logic [DW-1:0] m0_rdata, m1_rdata;
   logic          bank_sel, pic_ready, disp_ack;

   frame_swap_ctrl #(.AW(AW), .DW(DW), .RD_LAT(1)) i_frame_swap_ctrl (
      .clk(clk), .rst_n(rst_n), .frame_done(frame_done), .draw_stall(draw_stall),
      .draw_addr(draw_addr), .draw_wdata(draw_wdata), .draw_rd(draw_rd),
      .draw_wr(draw_wr), .draw_sel(draw_sel), .draw_rdata(draw_rdata),
      .disp_eof(disp_eof), .disp_addr(disp_addr), .disp_rd(disp_rd),
      .disp_sel(disp_sel), .disp_rdata(disp_rdata),
      .m0_addr(m0_addr), .m0_wdata(m0_wdata), .m0_rd(m0_rd), .m0_wr(m0_wr),
      .m0_sel(m0_sel), .m0_rdata(m0_rdata),
      .m1_addr(m1_addr), .m1_wdata(m1_wdata), .m1_rd(m1_rd), .m1_wr(m1_wr),
      .m1_sel(m1_sel), .m1_rdata(m1_rdata),
      .bank_sel(bank_sel), .pic_ready(pic_ready), .disp_ack(disp_ack)
   );

   // Two synchronous memories, preloaded under reset: mem0[a]=0x80+a, mem1[a]=0x40+a.
   logic [DW-1:0] mem0 [16];
   logic [DW-1:0] mem1 [16];
   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 16; i++) begin
            mem0[i] <= 8'h80 + 8'(i);
            mem1[i] <= 8'h40 + 8'(i);
         end
         m0_rdata <= '0;
         m1_rdata <= '0;
      end else begin
         if (m0_sel && m0_wr) mem0[m0_addr] <= m0_wdata;
         if (m0_sel && m0_rd) m0_rdata <= mem0[m0_addr];
         if (m1_sel && m1_wr) mem1[m1_addr] <= m1_wdata;
         if (m1_sel && m1_rd) m1_rdata <= mem1[m1_addr];
      end
   end

   int checks = 0;
   int fails  = 0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic idle_ports();
      draw_rd = 0; draw_wr = 0; draw_sel = 0;
      disp_rd = 0; disp_sel = 0;
      frame_done = 0; disp_eof = 0;
   endtask

   // Handshake table: {frame_done, disp_eof, exp pic_ready, exp disp_ack, exp bank_sel}
   localparam int NSTEP = 15;
   localparam logic [4:0] STEPS [NSTEP] = '{
      5'b01_000,  // eof, no picture: nothing (R3)
      5'b10_100,  // frame done: pic set (R2)
      5'b10_100,  // duplicate done ignored (R7)
      5'b00_100,  // waiting, stall held (R6)
      5'b01_110,  // eof with pic: ack (R4)
      5'b00_001,  // swap (R5)
      5'b00_001,
      5'b11_101,  // both strobes together: eof sees pic still low
      5'b01_111,
      5'b10_000,  // swap cycle; done ignored (R7)
      5'b00_000,  // no second swap (R7)
      5'b10_100,
      5'b00_100,
      5'b01_110,
      5'b01_001   // eof during swap cycle
   };

   initial begin
      repeat (20000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) step();
      rst_n = 1'b1;
      #1;
      // R1 reset state
      chk("R1 bank_sel", 32'(bank_sel), 0);
      chk("R1 pic_ready", 32'(pic_ready), 0);
      chk("R1 disp_ack", 32'(disp_ack), 0);
      chk("R1 draw_stall", 32'(draw_stall), 0);

      // R8 routing with bank 0 drawing
      draw_addr = 4'd5; draw_wdata = 8'h11; draw_wr = 1; draw_sel = 1;
      disp_addr = 4'd9; disp_rd = 1; disp_sel = 1;
      #1;
      chk("R8 m0_addr", 32'(m0_addr), 5);
      chk("R8 m0_wdata", 32'(m0_wdata), 32'h11);
      chk("R8 m0_wr", 32'(m0_wr), 1);
      chk("R8 m1_addr", 32'(m1_addr), 9);
      chk("R8 m1_wr", 32'(m1_wr), 0);
      chk("R8 m1_wdata", 32'(m1_wdata), 0);
      chk("R8 m1_rd", 32'(m1_rd), 1);
      step();
      chk("R9 display read bank0 map", 32'(disp_rdata), 32'h49);
      draw_wr = 0; draw_rd = 1; disp_rd = 0; disp_sel = 0;
      step();
      chk("R8/R9 drawn word read back", 32'(draw_rdata), 32'h11);
      idle_ports();

      // R2/R3/R4/R5/R6/R7 handshake table
      for (int s = 0; s < NSTEP; s++) begin
         frame_done = STEPS[s][4];
         disp_eof   = STEPS[s][3];
         step();
         chk($sformatf("R2/R3/R4/R5/R7 step %0d pic_ready", s), 32'(pic_ready), 32'(STEPS[s][2]));
         chk($sformatf("R3/R4/R5 step %0d disp_ack", s), 32'(disp_ack), 32'(STEPS[s][1]));
         chk($sformatf("R3/R5/R7 step %0d bank_sel", s), 32'(bank_sel), 32'(STEPS[s][0]));
         chk($sformatf("R6 step %0d draw_stall", s), 32'(draw_stall), 32'(STEPS[s][2]));
      end
      idle_ports();

      // R8 routing with bank 1 drawing: the drawn frame is now on display
      draw_addr = 4'd5; draw_wdata = 8'h77; draw_wr = 1; draw_sel = 1;
      #1;
      chk("R8 m1_wr in bank1 map", 32'(m1_wr), 1);
      chk("R8 m0_wr in bank1 map", 32'(m0_wr), 0);
      draw_wr = 0; draw_rd = 1;
      disp_addr = 4'd5; disp_rd = 1; disp_sel = 1;
      #1;
      chk("R8 m1_addr", 32'(m1_addr), 5);
      chk("R8 m0_rd", 32'(m0_rd), 1);
      step();
      chk("R9 draw read bank1 map", 32'(draw_rdata), 32'h45);
      chk("R9 display shows drawn frame", 32'(disp_rdata), 32'h11);
      idle_ports();

      // R9 read issued in the swap cycle
      frame_done = 1; step();
      frame_done = 0; disp_eof = 1; step();
      disp_eof = 0;
      chk("R4 ack before swap", 32'(disp_ack), 1);
      draw_addr = 4'd2; draw_rd = 1; draw_sel = 1;
      disp_addr = 4'd3; disp_rd = 1; disp_sel = 1;
      step();
      chk("R5 swapped to bank0", 32'(bank_sel), 0);
      chk("R9 draw data from issuing map", 32'(draw_rdata), 32'h42);
      chk("R9 display data from issuing map", 32'(disp_rdata), 32'h83);
      idle_ports();

      // R10 swap timing relative to the end-of-frame strobe
      frame_done = 1; step();
      frame_done = 0; disp_eof = 1; step();      // cycle k
      disp_eof = 0; disp_addr = 4'd3; disp_rd = 1; disp_sel = 1;
      #1;
      chk("R10 k+1 display still on m1", 32'(m1_rd), 1);
      chk("R10 k+1 display not on m0", 32'(m0_rd), 0);
      step();                                    // cycle k+2
      chk("R10 k+2 display on m0", 32'(m0_rd), 1);
      chk("R10 k+2 display off m1", 32'(m1_rd), 0);
      chk("R10 bank after swap", 32'(bank_sel), 1);
      idle_ports();
      step();

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule